// File: doc/BRIEF.md
# DDR2 Burst Read Responder

This block is the read path of a DDR2-style SDRAM device model. On each rising clock edge it decodes the command pins. When it sees a read, it captures the starting column and holds the request in a latency pipeline. After the programmed read latency it drives a burst of 4 or 8 words together with a data strobe. The read latency is the sum of the additive latency and the CAS latency.

Double data rate is carried as a word pair per clock. `dq_rise_o` holds the word that goes with the rising strobe edge and `dq_fall_o` holds the word that goes with the falling edge. The strobe has one preamble clock, driven low, ahead of the first pair, unless a burst is already running in that clock.

Read data comes from a small register array that is preloaded at reset with a fixed pattern per column. The three configuration inputs (CAS latency, additive latency and burst length) are static. They may change only while no read is pending. A new read must come at least BL/2 clocks after the previous one.

Top module: `ddr2_burst_reader`

## Requirements
- R1: A read is decoded at a rising edge when `cs_n_i`=0, `ras_n_i`=1, `cas_n_i`=0 and `we_n_i`=1; `col_i` sampled at that edge is the starting column.
- R2: Every other pin combination, and any cycle with `cs_n_i`=1, is a no-operation that starts nothing and leaves a pending or running burst unchanged.
- R3: The first word pair is on the outputs in the clock that begins `add_lat_i + cas_lat_i` edges after the read edge.
- R4: In the clock before the first pair, the strobe is enabled and driven low (`dqs_oe_o`=1, `dqs_o`=0), data is disabled and zero, for exactly one clock.
- R5: In every data clock `dqs_oe_o`=1, `dq_oe_o`=1 and `dqs_o`=1, so that the rise word lines up with the strobe's rising edge and the fall word with its falling edge.
- R6: `bl8_i`=0 gives 4 words over 2 clocks; `bl8_i`=1 gives 8 words over 4 clocks.
- R7: Word j of a burst (j from 0) comes from column {start[COL_W-1:k], (start[k-1:0]+j) mod 2^k}, with k=2 for BL4 and k=3 for BL8, so the burst wraps inside its aligned block. Pair p carries words 2p (rise) and 2p+1 (fall).
- R8: Column c holds the low DW bits of (c × 0x0F1D) XOR 0x5A5A.
- R9: Outside the preamble and data clocks, all outputs are 0 (strobe and data released).
- R10: A read issued exactly BL/2 clocks after the previous one continues the data without a gap and without a preamble clock; the strobe stays enabled.
- R11: While `rst_ni` is low, all outputs are 0.
- R12: `cas_lat_i` lies in 2..MAX_CL and `add_lat_i` in 0..MAX_AL, and none of the three configuration inputs changes while a read is pending or bursting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe command pin, active low |
| cas_n_i | input | 1 | Column strobe command pin, active low |
| we_n_i | input | 1 | Write enable command pin, active low |
| col_i | input | COL_W | Starting column, sampled with the read |
| cas_lat_i | input | $clog2(MAX_CL+1) | CAS latency in clocks |
| add_lat_i | input | $clog2(MAX_AL+1) | Additive latency in clocks |
| bl8_i | input | 1 | Burst length select: 1 = 8, 0 = 4 |
| dqs_o | output | 1 | Strobe level for the clock: high = rise/fall pulse, low = preamble |
| dqs_oe_o | output | 1 | Strobe output enable |
| dq_oe_o | output | 1 | Data output enable |
| dq_rise_o | output | DW | Word aligned to the rising strobe edge |
| dq_fall_o | output | DW | Word aligned to the falling strobe edge |

## Verification
Two functions can fall in the same clock here: the preamble slot of a new read and the final data pair of the burst before it. This happens whenever two reads are exactly BL/2 clocks apart. The bench provokes it with directed back-to-back reads at both burst lengths, and also at random through read gaps that range from BL/2 to BL/2+3. The bench keeps per-cycle expectations in which a data slot always wins over a preamble slot. A correct design therefore shows unbroken data with the strobe held high, and a preamble only when the previous burst has already ended. Non-read commands, including a read pattern with chip select high, are mixed into the same windows to show that in-flight bursts are not disturbed.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DATA = 2'd2
  } rd_phase_e;

  // preload pattern of the column store
  function automatic logic [31:0] col_pattern(int unsigned c);
    return (32'(c) * 32'h0000_0F1D) ^ 32'h0000_5A5A;
  endfunction

endpackage

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned DEPTH = 10,
  localparam int unsigned RLW  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [RLW-1:0]   rl_i,
  output logic             start_o,
  output logic [COL_W-1:0] start_col_o,
  output logic             pre_o,
  output logic             busy_o
);

  logic [DEPTH-1:0] vld_q;
  logic [COL_W-1:0] col_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      col_q[0] <= '0;
    end else begin
      vld_q    <= {vld_q[DEPTH-2:0], push_i};
      col_q[0] <= col_i;
    end
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) col_q[k] <= '0;
      else         col_q[k] <= col_q[k-1];
    end
  end

  // stage rl-1 starts the burst, stage rl-2 asks for the preamble
  always_comb begin
    start_o     = 1'b0;
    start_col_o = '0;
    pre_o       = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (RLW'(k + 1) == rl_i) begin
        start_o     = vld_q[k];
        start_col_o = col_q[k];
      end
      if (RLW'(k + 2) == rl_i) pre_o = vld_q[k];
    end
  end

  assign busy_o = |vld_q;

endmodule

// File: rtl/rd_col_store.sv
module rd_col_store import ddr_rd_pkg::*; #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned DW    = 16,
  localparam int unsigned NCOL = 1 << COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] addr_a_i,
  input  logic [COL_W-1:0] addr_b_i,
  output logic [DW-1:0]    data_a_o,
  output logic [DW-1:0]    data_b_o
);

  logic [DW-1:0] mem_q [NCOL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCOL; i++) mem_q[i] <= DW'(col_pattern(i));
    end else begin
      for (int i = 0; i < NCOL; i++) mem_q[i] <= mem_q[i];
    end
  end

  assign data_a_o = mem_q[addr_a_i];
  assign data_b_o = mem_q[addr_b_i];

endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq import ddr_rd_pkg::*; #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             pre_i,
  input  logic             bl8_i,
  output logic [COL_W-1:0] rd_a_o,
  output logic [COL_W-1:0] rd_b_o,
  input  logic [DW-1:0]    rd_a_dat_i,
  input  logic [DW-1:0]    rd_b_dat_i,
  output logic             dqs_o,
  output logic             dqs_oe_o,
  output logic             dq_oe_o,
  output logic [DW-1:0]    rise_o,
  output logic [DW-1:0]    fall_o,
  output logic             busy_o
);

  rd_phase_e        phase_q, phase_d;
  logic [1:0]       left_q, idx_q, pair, run_q;
  logic [COL_W-1:0] base_q, base;
  logic [DW-1:0]    rise_q, fall_q;
  logic             emit;

  function automatic logic [COL_W-1:0] wrap_col(logic [COL_W-1:0] b, logic [2:0] j, logic b8);
    if (b8) return {b[COL_W-1:3], b[2:0] + j};
    return {b[COL_W-1:2], b[1:0] + j[1:0]};
  endfunction

  assign emit = start_i || (left_q != 2'd0);
  assign base = start_i ? start_col_i : base_q;
  assign pair = start_i ? 2'd0 : idx_q;

  assign rd_a_o = wrap_col(base, {pair, 1'b0}, bl8_i);
  assign rd_b_o = wrap_col(base, {pair, 1'b1}, bl8_i);

  // a running burst beats a preamble request (seamless reads)
  always_comb begin
    if (emit)       phase_d = PH_DATA;
    else if (pre_i) phase_d = PH_PRE;
    else            phase_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      idx_q   <= '0;
      base_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      run_q   <= '0;
    end else begin
      phase_q <= phase_d;
      rise_q  <= emit ? rd_a_dat_i : '0;
      fall_q  <= emit ? rd_b_dat_i : '0;
      run_q   <= (phase_d == PH_DATA) ? run_q + 2'd1 : 2'd0;
      if (start_i) begin
        left_q <= bl8_i ? 2'd3 : 2'd1;
        idx_q  <= 2'd1;
        base_q <= start_col_i;
      end else if (left_q != 2'd0) begin
        left_q <= left_q - 2'd1;
        idx_q  <= idx_q + 2'd1;
      end
    end
  end

  assign dqs_o    = (phase_q == PH_DATA);
  assign dqs_oe_o = (phase_q != PH_IDLE);
  assign dq_oe_o  = (phase_q == PH_DATA);
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign busy_o   = (phase_q != PH_IDLE) || (left_q != 2'd0);

  // R4
  pre_then_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_PRE |=> phase_q == PH_DATA);

  // R6
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_DATA && $past(phase_q) == PH_DATA)
      |-> (bl8_i ? ($past(run_q) == 2'd0) : !$past(run_q[0])));

endmodule

// File: rtl/ddr2_burst_reader.sv
module ddr2_burst_reader #(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned DW     = 16,
  parameter int unsigned MAX_AL = 4,
  parameter int unsigned MAX_CL = 6,
  localparam int unsigned ALW   = $clog2(MAX_AL + 1),
  localparam int unsigned CLW   = $clog2(MAX_CL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             we_n_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [CLW-1:0]   cas_lat_i,
  input  logic [ALW-1:0]   add_lat_i,
  input  logic             bl8_i,
  output logic             dqs_o,
  output logic             dqs_oe_o,
  output logic             dq_oe_o,
  output logic [DW-1:0]    dq_rise_o,
  output logic [DW-1:0]    dq_fall_o
);

  localparam int unsigned MAX_RL = MAX_AL + MAX_CL;
  localparam int unsigned RLW    = $clog2(MAX_RL + 1);

  logic             rd_cmd, start, pre, pipe_busy, seq_busy;
  logic [RLW-1:0]   rl;
  logic [COL_W-1:0] start_col, rd_a, rd_b;
  logic [DW-1:0]    rd_a_dat, rd_b_dat;

  assign rd_cmd = !cs_n_i && ras_n_i && !cas_n_i && we_n_i;
  assign rl     = RLW'(cas_lat_i) + RLW'(add_lat_i);

  rd_lat_pipe #(.COL_W(COL_W), .DEPTH(MAX_RL)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rd_cmd),
    .col_i       (col_i),
    .rl_i        (rl),
    .start_o     (start),
    .start_col_o (start_col),
    .pre_o       (pre),
    .busy_o      (pipe_busy)
  );

  rd_col_store #(.COL_W(COL_W), .DW(DW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_a_i (rd_a),
    .addr_b_i (rd_b),
    .data_a_o (rd_a_dat),
    .data_b_o (rd_b_dat)
  );

  rd_burst_seq #(.COL_W(COL_W), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_col_i (start_col),
    .pre_i       (pre),
    .bl8_i       (bl8_i),
    .rd_a_o      (rd_a),
    .rd_b_o      (rd_b),
    .rd_a_dat_i  (rd_a_dat),
    .rd_b_dat_i  (rd_b_dat),
    .dqs_o       (dqs_o),
    .dqs_oe_o    (dqs_oe_o),
    .dq_oe_o     (dq_oe_o),
    .rise_o      (dq_rise_o),
    .fall_o      (dq_fall_o),
    .busy_o      (seq_busy)
  );

  // R12
  cfg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_lat_i >= CLW'(2) && cas_lat_i <= CLW'(MAX_CL) && add_lat_i <= ALW'(MAX_AL));

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_busy || seq_busy) |-> $stable({cas_lat_i, add_lat_i, bl8_i}));

endmodule

// File: tb/tb_ddr2_burst_reader.sv
`timescale 1ns/1ps
module tb_ddr2_burst_reader;
  localparam int COL_W = 6, DW = 16, MAX_AL = 4, MAX_CL = 6;
  localparam int NC = 16384;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [COL_W-1:0] col = '0;
  logic [2:0] cl = 3'd3, al = 3'd0;
  logic b8 = 1'b0;
  logic dqs, dqs_oe, dq_oe;
  logic [DW-1:0] rise, fall;

  always #2 clk = ~clk;

  ddr2_burst_reader #(.COL_W(COL_W), .DW(DW), .MAX_AL(MAX_AL), .MAX_CL(MAX_CL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .col_i(col), .cas_lat_i(cl), .add_lat_i(al), .bl8_i(b8),
    .dqs_o(dqs), .dqs_oe_o(dqs_oe), .dq_oe_o(dq_oe), .dq_rise_o(rise), .dq_fall_o(fall));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit            exp_dv  [NC];
  bit            exp_pre [NC];
  logic [DW-1:0] exp_r   [NC];
  logic [DW-1:0] exp_f   [NC];
  int n_chk = 0, n_fail = 0;
  bit chk_en = 0;
  string sec = "R11";

  // R8 content
  function automatic logic [DW-1:0] word_of(int c);
    logic [31:0] v = (32'(c) * 32'd3869) ^ 32'd23130;
    return v[DW-1:0];
  endfunction

  // R7 order
  function automatic int burst_col(int start, int j, bit bl8);
    int m = bl8 ? 8 : 4;
    return (start & ~(m - 1)) | ((start + j) & (m - 1));
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] cyc %0d actual %h expected %h", tag, sec, cyc, act, exp);
    end
  endtask

  task automatic schedule(int t0, int start);
    int rl = int'(cl) + int'(al);
    int h = b8 ? 4 : 2;
    for (int p = 0; p < h; p++) begin
      exp_dv[t0 + rl + p] = 1;
      exp_r[t0 + rl + p]  = word_of(burst_col(start, 2 * p, b8));
      exp_f[t0 + rl + p]  = word_of(burst_col(start, 2 * p + 1, b8));
    end
    exp_pre[t0 + rl - 1] = 1;
  endtask

  always @(negedge clk) begin
    if (chk_en && cyc < NC) begin
      if (exp_dv[cyc]) begin
        check("R3 R6 dq_oe", dq_oe, 1);
        check("R5 dqs_oe", dqs_oe, 1);
        check("R5 dqs", dqs, 1);
        check("R7 R8 rise", rise, exp_r[cyc]);
        check("R7 R8 fall", fall, exp_f[cyc]);
      end else if (exp_pre[cyc]) begin
        check("R4 dqs_oe", dqs_oe, 1);
        check("R4 dqs", dqs, 0);
        check("R4 dq_oe", dq_oe, 0);
        check("R4 rise", rise, 0);
      end else begin
        check("R9 dqs_oe", dqs_oe, 0);
        check("R9 dq_oe", dq_oe, 0);
        check("R9 dqs", dqs, 0);
        check("R9 data", rise | fall, 0);
      end
    end
  end

  task automatic step(logic c, logic r, logic a, logic w, int addr);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; col = COL_W'(addr);
    // R1 decode
    if (!c && r && !a && w) schedule(cyc + 1, addr & ((1 << COL_W) - 1));
  endtask

  task automatic rd(int addr);
    step(0, 1, 0, 1, addr);
  endtask

  // R2 non-read commands
  task automatic nops(int n);
    for (int i = 0; i < n; i++) begin
      case ($urandom % 4)
        0: step(1, 1'($urandom), 1'($urandom), 1'($urandom), $urandom);
        1: step(0, 1, 1, 1, $urandom);
        2: step(0, 1, 0, 0, $urandom);
        default: step(0, 0, 1, 1, $urandom);
      endcase
    end
  endtask

  // R12 config only changes while idle
  task automatic set_cfg(int c, int a, bit b);
    nops(MAX_AL + MAX_CL + 8);
    @(negedge clk);
    cl = 3'(c); al = 3'(a); b8 = b;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cyc %0d", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R11 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R11 dqs_oe", dqs_oe, 0);
      check("R11 dq_oe", dq_oe, 0);
      check("R11 data", rise | fall | DW'(dqs), 0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    chk_en = 1;

    sec = "R3 AL0 CL3";
    set_cfg(3, 0, 0);
    rd(5);
    nops(10);

    sec = "R10 BL8";
    set_cfg(4, 1, 1);
    rd(13); nops(3); rd(22); nops(4); rd(47);
    nops(12);

    sec = "R10 BL4";
    set_cfg(2, 0, 0);
    rd(2); nops(1); rd(63); nops(2); rd(30);
    nops(10);

    sec = "R2 in flight";
    set_cfg(3, 2, 1);
    rd(40);
    step(1, 1, 0, 1, 7);
    step(0, 1, 0, 0, 3);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 9);
    nops(12);

    sec = "R1 R6 R7 random";
    for (int s = 0; s < 8; s++) begin
      set_cfg(2 + int'($urandom % (MAX_CL - 1)), int'($urandom % (MAX_AL + 1)), 1'($urandom));
      for (int k = 0; k < 30; k++) begin
        rd($urandom);
        nops((b8 ? 3 : 1) + int'($urandom % 4));
      end
    end
    nops(MAX_AL + MAX_CL + 8);

    chk_en = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule